// File: doc/BRIEF.md
# Character I/O and Program Interrupt Controller

This block sits beside the control unit of a small accumulator machine. It holds one 8-bit character arriving from an input device and one 8-bit character leaving for an output device. Each character register has a ready flag. It also holds an interrupt-enable bit and an interrupt-pending bit. When the control unit presents a register-reference I/O instruction at timing step T3, the block carries out the operation selected by a single bit of instruction-register bits 11..6. It then tells the sequencer to return to T0, and when a skip condition holds it also asks for an extra PC increment.

The sequencer reads the pending bit. While that bit is set, the three steps that would normally fetch an instruction run the interrupt cycle instead. In step 0 the block captures PC and points the memory address at word 0. In step 1 it writes the captured PC into word 0 and clears PC. In step 2 it increments PC to 1, clears interrupt enable and the pending bit, and resets the sequencer. Software can poll the flags with the skip instructions, or it can enable interrupts and let either flag start the service routine at address 1.

Top module: `chario_irq_ctl`

## Requirements
- R1: After reset, `in_ready_o`=1 (input flag clear), `out_valid_o`=0 (output flag set), `ien_o`=0 and `irq_o`=0.
- R2: A device write (`in_valid_i`=1) while `in_ready_o`=1 stores `in_data_i`, and `in_ready_o` drops on the next cycle. A write while `in_ready_o`=0 is ignored, and the held character on `acc_din_o` stays unchanged.
- R3: An I/O instruction exists when `op_d7_i`=1, `ind_i`=1 and `step_i`=3. If that instruction has `ir_i[11]`=1, `acc_ld_o` is 1 in that cycle with the held character on `acc_din_o`, and `in_ready_o` is 1 on the following cycle.
- R4: An I/O instruction with `ir_i[10]`=1 copies `acc_lo_i` to `out_data_o` and raises `out_valid_o` on the next cycle. A pulse on `out_done_i` while `out_valid_o`=1 lowers `out_valid_o` on the following cycle.
- R5: An I/O instruction with `ir_i[9]`=1 drives `pc_inc_o`=1 in that cycle exactly when the input flag is set (`in_ready_o`=0). An I/O instruction with `ir_i[8]`=1 drives `pc_inc_o`=1 exactly when the output flag is set (`out_valid_o`=0).
- R6: An I/O instruction with `ir_i[7]`=1 sets `ien_o` on the next cycle. An I/O instruction with `ir_i[6]`=1 clears it, and the clear wins when both bits are set.
- R7: When `op_d7_i`, `ind_i` and `step_i`=3 do not all hold and no interrupt cycle runs, `acc_ld_o`, `pc_inc_o`, `pc_clr_o`, `seq_clr_o` and `mem_we_o` stay 0, and the flags keep their values.
- R8: Every I/O instruction drives `seq_clr_o`=1 in its T3 cycle.
- R9: At a clock edge where `step_i` is 3 or more, `ien_o`=1 and either flag is set, `irq_o` becomes 1. No clock edge in steps 0..2 sets it, and no clock edge with `ien_o`=0 sets it.
- R10: While `irq_o`=1, the steps run as follows. In step 0, `mem_addr_o`=0 and PC is captured. In step 1, `mem_we_o`=1, `pc_clr_o`=1, `mem_addr_o`=0, and `mem_wdata_o` equals the PC captured in step 0, zero-extended. In step 2, `pc_inc_o`=1 and `seq_clr_o`=1, and on the next cycle `irq_o`=0 and `ien_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 3 | Current timing step from the sequence counter |
| op_d7_i | input | 1 | Decoded opcode line 7 |
| ind_i | input | 1 | Indirect / mode bit of the instruction |
| ir_i | input | 6 | Instruction register bits 11..6 (operation select) |
| acc_lo_i | input | 8 | Accumulator low byte |
| acc_ld_o | output | 1 | Load accumulator low byte from `acc_din_o` |
| acc_din_o | output | 8 | Held input character |
| pc_i | input | 12 | Current program counter |
| pc_inc_o | output | 1 | Increment PC this edge |
| pc_clr_o | output | 1 | Clear PC this edge |
| seq_clr_o | output | 1 | Return sequence counter to T0 |
| mem_addr_o | output | 12 | Memory address (0 during the interrupt cycle, else PC) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 16 | Memory write data (saved return address) |
| in_valid_i | input | 1 | Input device offers a character |
| in_data_i | input | 8 | Character from the input device |
| in_ready_o | output | 1 | Input register empty (input flag clear) |
| out_valid_o | output | 1 | Output character pending (output flag clear) |
| out_data_o | output | 8 | Character for the output device |
| out_done_i | input | 1 | Output device finished its character |
| ien_o | output | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt pending; selects the interrupt cycle |

## Verification
The bench offers a second character while the first is still held. A design that overwrote it would show the new byte on `acc_din_o`. The bench also changes PC between step 0 and step 1 of the interrupt cycle. A design that wrote the live PC instead of the captured one would store the wrong return address. The bench enables interrupts while both flags are clear and then lets a flag rise. A design that set the pending bit without checking the flags, or during steps 0..2, would interrupt too early. Finally, the bench sets both enable bits in one instruction and checks that the clear wins. It also holds T3 with only the opcode line or only the mode bit set, which must produce no action.

// File: rtl/chario_pkg.sv
package chario_pkg;

    localparam int CHAR_W   = 8;
    localparam int ADDR_W   = 12;
    localparam int WORD_W   = 16;
    localparam int STEP_W   = 3;
    localparam int IR_HI    = 11;
    localparam int IR_LO    = 6;
    localparam int IO_STEP  = 3;
    localparam int IC_STEPS = 3;
    localparam int RET_ADDR = 0;

    localparam int SEL_INP = 11;
    localparam int SEL_OUT = 10;
    localparam int SEL_SKI = 9;
    localparam int SEL_SKO = 8;
    localparam int SEL_ION = 7;
    localparam int SEL_IOF = 6;

    typedef struct packed {
        logic inp;
        logic outp;
        logic ski;
        logic sko;
        logic ion;
        logic iof;
    } io_cmd_t;

    typedef enum logic [1:0] {
        IC_NONE  = 2'd0,
        IC_SAVE  = 2'd1,
        IC_STORE = 2'd2,
        IC_ENTER = 2'd3
    } ic_phase_t;

    function automatic io_cmd_t io_split(input logic [IR_HI:IR_LO] f);
        io_cmd_t c;
        c.inp  = f[SEL_INP];
        c.outp = f[SEL_OUT];
        c.ski  = f[SEL_SKI];
        c.sko  = f[SEL_SKO];
        c.ion  = f[SEL_ION];
        c.iof  = f[SEL_IOF];
        return c;
    endfunction

endpackage

// File: rtl/chario_decode.sv
module chario_decode
    import chario_pkg::*;
#(
    parameter int SW        = STEP_W,
    parameter int EXEC_STEP = IO_STEP
) (
    input  logic [SW-1:0]      step_i,
    input  logic               op_d7_i,
    input  logic               ind_i,
    input  logic [IR_HI:IR_LO] ir_i,
    output logic               exec_o,
    output io_cmd_t            cmd_o
);

    always_comb begin
        exec_o = op_d7_i && ind_i && (step_i == SW'(EXEC_STEP));
        cmd_o  = exec_o ? io_split(ir_i) : '0;
    end

endmodule

// File: rtl/chario_inbuf.sv
module chario_inbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dev_valid_i,
    input  logic [W-1:0] dev_data_i,
    input  logic         take_i,
    output logic         full_o,
    output logic [W-1:0] data_o
);

    logic         full_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (dev_valid_i && !full_q) begin
            full_q <= 1'b1;
            data_q <= dev_data_i;
        end else if (take_i) begin
            full_q <= 1'b0;
        end
    end

    assign full_o = full_q;
    assign data_o = data_q;

endmodule

// File: rtl/chario_outbuf.sv
module chario_outbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_data_i,
    input  logic         dev_done_i,
    output logic         idle_o,
    output logic [W-1:0] data_o
);

    logic         idle_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= 1'b1;
            data_q <= '0;
        end else if (load_i) begin
            idle_q <= 1'b0;
            data_q <= load_data_i;
        end else if (dev_done_i && !idle_q) begin
            idle_q <= 1'b1;
        end
    end

    assign idle_o = idle_q;
    assign data_o = data_q;

endmodule

// File: rtl/chario_irqseq.sv
module chario_irqseq
    import chario_pkg::*;
#(
    parameter int SW = STEP_W,
    parameter int AW = ADDR_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] step_i,
    input  logic          flag_any_i,
    input  logic          ion_i,
    input  logic          iof_i,
    input  logic [AW-1:0] pc_i,
    output logic          ien_o,
    output logic          pend_o,
    output logic          vec_sel_o,
    output logic          mem_we_o,
    output logic          pc_clr_o,
    output logic          pc_inc_o,
    output logic          seq_clr_o,
    output logic [WW-1:0] ret_word_o
);

    logic          ien_q;
    logic          pend_q;
    logic [AW-1:0] ret_q;
    ic_phase_t     ph;
    logic          may_arm;

    always_comb begin
        if (!pend_q || step_i >= SW'(IC_STEPS)) begin
            ph = IC_NONE;
        end else begin
            ph = ic_phase_t'(step_i[1:0] + 2'd1);
        end
        may_arm = ien_q && flag_any_i && (step_i >= SW'(IC_STEPS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= 1'b0;
            pend_q <= 1'b0;
            ret_q  <= '0;
        end else begin
            if (ph == IC_SAVE) begin
                ret_q <= pc_i;
            end
            if (ph == IC_ENTER) begin
                ien_q  <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                if (iof_i) begin
                    ien_q <= 1'b0;
                end else if (ion_i) begin
                    ien_q <= 1'b1;
                end
                if (may_arm) begin
                    pend_q <= 1'b1;
                end
            end
        end
    end

    assign ien_o      = ien_q;
    assign pend_o     = pend_q;
    assign vec_sel_o  = (ph != IC_NONE);
    assign mem_we_o   = (ph == IC_STORE);
    assign pc_clr_o   = (ph == IC_STORE);
    assign pc_inc_o   = (ph == IC_ENTER);
    assign seq_clr_o  = (ph == IC_ENTER);
    assign ret_word_o = WW'(ret_q);

endmodule

// File: rtl/chario_irq_ctl.sv
module chario_irq_ctl
    import chario_pkg::*;
#(
    parameter int CW = CHAR_W,
    parameter int AW = ADDR_W,
    parameter int WW = WORD_W,
    parameter int SW = STEP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SW-1:0]      step_i,
    input  logic               op_d7_i,
    input  logic               ind_i,
    input  logic [IR_HI:IR_LO] ir_i,
    input  logic [CW-1:0]      acc_lo_i,
    output logic               acc_ld_o,
    output logic [CW-1:0]      acc_din_o,
    input  logic [AW-1:0]      pc_i,
    output logic               pc_inc_o,
    output logic               pc_clr_o,
    output logic               seq_clr_o,
    output logic [AW-1:0]      mem_addr_o,
    output logic               mem_we_o,
    output logic [WW-1:0]      mem_wdata_o,
    input  logic               in_valid_i,
    input  logic [CW-1:0]      in_data_i,
    output logic               in_ready_o,
    output logic               out_valid_o,
    output logic [CW-1:0]      out_data_o,
    input  logic               out_done_i,
    output logic               ien_o,
    output logic               irq_o
);

    logic    exec;
    io_cmd_t cmd;
    logic    in_full;
    logic    out_idle;
    logic    vec_sel;
    logic    ic_we, ic_clr, ic_inc, ic_seq;
    logic    skip_hit;

    chario_decode #(.SW(SW), .EXEC_STEP(IO_STEP)) u_dec (
        .step_i  (step_i),
        .op_d7_i (op_d7_i),
        .ind_i   (ind_i),
        .ir_i    (ir_i),
        .exec_o  (exec),
        .cmd_o   (cmd)
    );

    chario_inbuf #(.W(CW)) u_in (
        .clk         (clk),
        .rst         (rst),
        .dev_valid_i (in_valid_i),
        .dev_data_i  (in_data_i),
        .take_i      (cmd.inp),
        .full_o      (in_full),
        .data_o      (acc_din_o)
    );

    chario_outbuf #(.W(CW)) u_out (
        .clk         (clk),
        .rst         (rst),
        .load_i      (cmd.outp),
        .load_data_i (acc_lo_i),
        .dev_done_i  (out_done_i),
        .idle_o      (out_idle),
        .data_o      (out_data_o)
    );

    chario_irqseq #(.SW(SW), .AW(AW), .WW(WW)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .step_i     (step_i),
        .flag_any_i (in_full || out_idle),
        .ion_i      (cmd.ion),
        .iof_i      (cmd.iof),
        .pc_i       (pc_i),
        .ien_o      (ien_o),
        .pend_o     (irq_o),
        .vec_sel_o  (vec_sel),
        .mem_we_o   (ic_we),
        .pc_clr_o   (ic_clr),
        .pc_inc_o   (ic_inc),
        .seq_clr_o  (ic_seq),
        .ret_word_o (mem_wdata_o)
    );

    always_comb begin
        skip_hit    = (cmd.ski && in_full) || (cmd.sko && out_idle);
        acc_ld_o    = cmd.inp;
        pc_inc_o    = skip_hit || ic_inc;
        pc_clr_o    = ic_clr;
        seq_clr_o   = exec || ic_seq;
        mem_we_o    = ic_we;
        mem_addr_o  = vec_sel ? AW'(RET_ADDR) : pc_i;
        in_ready_o  = !in_full;
        out_valid_o = !out_idle;
    end

endmodule

// File: rtl/chario_irq_ctl_chk.sv
module chario_irq_ctl_chk
    import chario_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [STEP_W-1:0]  step_i,
    input logic               op_d7_i,
    input logic               ind_i,
    input logic [IR_HI:IR_LO] ir_i,
    input logic [CHAR_W-1:0]  acc_lo_i,
    input logic               acc_ld_o,
    input logic [CHAR_W-1:0]  acc_din_o,
    input logic [ADDR_W-1:0]  pc_i,
    input logic               pc_inc_o,
    input logic               pc_clr_o,
    input logic               seq_clr_o,
    input logic [ADDR_W-1:0]  mem_addr_o,
    input logic               mem_we_o,
    input logic [WORD_W-1:0]  mem_wdata_o,
    input logic               in_ready_o,
    input logic               out_valid_o,
    input logic [CHAR_W-1:0]  out_data_o,
    input logic               ien_o,
    input logic               irq_o
);

    logic io_now;
    assign io_now = op_d7_i && ind_i && (step_i == STEP_W'(IO_STEP));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_ready_o && !(io_now && ir_i[SEL_INP]) |=> !in_ready_o && $stable(acc_din_o));

    p_take_r3: assert property (@(posedge clk) disable iff (rst)
        io_now && ir_i[SEL_INP] && !in_ready_o |=> in_ready_o);

    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        io_now && ir_i[SEL_INP] |-> acc_ld_o);

    p_out_r4: assert property (@(posedge clk) disable iff (rst)
        io_now && ir_i[SEL_OUT] |=> out_valid_o && out_data_o == $past(acc_lo_i));

    p_ion_r6: assert property (@(posedge clk) disable iff (rst)
        io_now && ir_i[SEL_ION] && !ir_i[SEL_IOF] |=> ien_o);

    p_iof_r6: assert property (@(posedge clk) disable iff (rst)
        io_now && ir_i[SEL_IOF] |=> !ien_o);

    p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !io_now && !irq_o |-> !acc_ld_o && !pc_inc_o && !pc_clr_o && !seq_clr_o && !mem_we_o);

    p_seq_r8: assert property (@(posedge clk) disable iff (rst)
        io_now |-> seq_clr_o);

    p_arm_r9: assert property (@(posedge clk) disable iff (rst)
        !irq_o && ien_o && step_i >= STEP_W'(IC_STEPS) && (!in_ready_o || !out_valid_o) |=> irq_o);

    p_noarm_r9: assert property (@(posedge clk) disable iff (rst)
        !irq_o && (!ien_o || step_i < STEP_W'(IC_STEPS)) |=> !irq_o);

    p_store_r10: assert property (@(posedge clk) disable iff (rst)
        irq_o && step_i == STEP_W'(1) && $past(irq_o) && $past(step_i) == STEP_W'(0)
        |-> mem_we_o && pc_clr_o && mem_addr_o == '0 && mem_wdata_o == WORD_W'($past(pc_i)));

    p_we_r10: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> irq_o && step_i == STEP_W'(1));

    p_enter_r10: assert property (@(posedge clk) disable iff (rst)
        irq_o && step_i == STEP_W'(2) |-> pc_inc_o && seq_clr_o);

    p_exit_r10: assert property (@(posedge clk) disable iff (rst)
        irq_o && step_i == STEP_W'(2) |=> !irq_o && !ien_o);

endmodule

bind chario_irq_ctl chario_irq_ctl_chk u_chk (.*);

// File: tb/sim_chario_irq_ctl.sv
module sim_chario_irq_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  step_i = 3'd4;
    logic        op_d7_i = 1'b0;
    logic        ind_i = 1'b0;
    logic [11:6] ir_i = '0;
    logic [7:0]  acc_lo_i = '0;
    logic        acc_ld_o;
    logic [7:0]  acc_din_o;
    logic [11:0] pc_i = '0;
    logic        pc_inc_o, pc_clr_o, seq_clr_o;
    logic [11:0] mem_addr_o;
    logic        mem_we_o;
    logic [15:0] mem_wdata_o;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_data_i = '0;
    logic        in_ready_o, out_valid_o;
    logic [7:0]  out_data_o;
    logic        out_done_i = 1'b0;
    logic        ien_o, irq_o;

    chario_irq_ctl u0 (.*);

    always #5 clk = ~clk;

    localparam int P_INRDY = 0, P_OUTVLD = 1, P_OUTDAT = 2, P_ACCLD = 3, P_ACCDIN = 4,
                   P_PCINC = 5, P_PCCLR = 6, P_SEQCLR = 7, P_MEMWE = 8, P_MEMAD = 9,
                   P_MEMWD = 10, P_IEN = 11, P_IRQ = 12;

    typedef struct {
        int          cyc;
        int          id;
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc_cnt = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    function automatic logic [15:0] probe(input int id);
        case (id)
            P_INRDY:  probe = {15'd0, in_ready_o};
            P_OUTVLD: probe = {15'd0, out_valid_o};
            P_OUTDAT: probe = {8'd0, out_data_o};
            P_ACCLD:  probe = {15'd0, acc_ld_o};
            P_ACCDIN: probe = {8'd0, acc_din_o};
            P_PCINC:  probe = {15'd0, pc_inc_o};
            P_PCCLR:  probe = {15'd0, pc_clr_o};
            P_SEQCLR: probe = {15'd0, seq_clr_o};
            P_MEMWE:  probe = {15'd0, mem_we_o};
            P_MEMAD:  probe = {4'd0, mem_addr_o};
            P_MEMWD:  probe = mem_wdata_o;
            P_IEN:    probe = {15'd0, ien_o};
            P_IRQ:    probe = {15'd0, irq_o};
            default:  probe = '0;
        endcase
    endfunction

    // monitor: pops the expectations of the current cycle mid-cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc_cnt) begin
            exp_t e;
            logic [15:0] act;
            e = q.pop_front();
            act = probe(e.id);
            n_chk++;
            if (act !== e.val) begin
                n_bad++;
                $display("FAIL %s actual=%0h expected=%0h", e.tag, act, e.val);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ex(input int id, input logic [15:0] v, input string t);
        exp_t e;
        e.cyc = cyc_cnt;
        e.id  = id;
        e.val = v;
        e.tag = t;
        q.push_back(e);
    endtask

    task automatic idle(input logic [2:0] st);
        step_i  = st;
        op_d7_i = 1'b0;
        ind_i   = 1'b0;
        ir_i    = '0;
    endtask

    task automatic ioi(input int b);
        step_i  = 3'd3;
        op_d7_i = 1'b1;
        ind_i   = 1'b1;
        ir_i    = '0;
        ir_i[b] = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        ex(P_INRDY, 1, "R1 in_ready");
        ex(P_OUTVLD, 0, "R1 out_valid");
        ex(P_IEN, 0, "R1 ien");
        ex(P_IRQ, 0, "R1 irq");

        // R2 capture and refusal while full
        tick(); in_valid_i = 1'b1; in_data_i = 8'h41;
        ex(P_INRDY, 1, "R2 ready before write");
        tick(); in_data_i = 8'h42;
        ex(P_INRDY, 0, "R2 full after write");
        ex(P_ACCDIN, 16'h41, "R2 held char");
        tick(); in_valid_i = 1'b0;
        ex(P_ACCDIN, 16'h41, "R2 second write ignored");
        ex(P_INRDY, 0, "R2 still full");

        // R7 no action without full decode
        tick(); ioi(11); ind_i = 1'b0;
        ex(P_ACCLD, 0, "R7 mode bit low");
        ex(P_SEQCLR, 0, "R7 mode bit low seq");
        tick(); ioi(11); step_i = 3'd2;
        ex(P_ACCLD, 0, "R7 wrong step");
        ex(P_PCINC, 0, "R7 wrong step pc");
        tick(); ioi(11); op_d7_i = 1'b0;
        ex(P_ACCLD, 0, "R7 opcode line low");
        tick(); idle(3'd4);
        ex(P_INRDY, 0, "R7 flag unchanged");

        // R5 skip on input flag set, R8 seq clear
        tick(); ioi(9);
        ex(P_PCINC, 1, "R5 skip input flag set");
        ex(P_SEQCLR, 1, "R8 seq clear on skip");

        // R3 take the character
        tick(); ioi(11);
        ex(P_ACCLD, 1, "R3 acc load");
        ex(P_ACCDIN, 16'h41, "R3 acc data");
        ex(P_SEQCLR, 1, "R8 seq clear on input");
        tick(); idle(3'd4);
        ex(P_INRDY, 1, "R3 flag cleared");
        tick(); ioi(9);
        ex(P_PCINC, 0, "R5 no skip input empty");

        // R4 output load
        tick(); ioi(8);
        ex(P_PCINC, 1, "R5 skip output flag set");
        tick(); ioi(10); acc_lo_i = 8'h5A;
        ex(P_ACCLD, 0, "R4 no acc load");
        ex(P_SEQCLR, 1, "R8 seq clear on output");
        tick(); idle(3'd4); acc_lo_i = 8'h00;
        ex(P_OUTVLD, 1, "R4 pending");
        ex(P_OUTDAT, 16'h5A, "R4 data");
        tick(); ioi(8);
        ex(P_PCINC, 0, "R5 no skip output busy");

        // R6 enable/disable, both flags clear now
        tick(); ioi(7); ir_i[6] = 1'b1;
        tick(); idle(3'd4);
        ex(P_IEN, 0, "R6 clear wins");
        tick(); ioi(7);
        tick(); idle(3'd4);
        ex(P_IEN, 1, "R6 enable");
        tick();
        ex(P_IRQ, 0, "R9 no flag no irq");
        tick(); ioi(6);
        tick(); idle(3'd4);
        ex(P_IEN, 0, "R6 disable");

        // R4 device completes
        tick(); out_done_i = 1'b1;
        ex(P_OUTVLD, 1, "R4 pending during done");
        tick(); out_done_i = 1'b0;
        ex(P_OUTVLD, 0, "R4 done clears pending");
        ex(P_IRQ, 0, "R9 flag set but disabled");

        // R9 arm, R10 interrupt cycle
        tick(); ioi(7);
        tick(); idle(3'd4);
        ex(P_IEN, 1, "R9 enabled");
        ex(P_IRQ, 0, "R9 not yet pending");
        tick(); idle(3'd0); pc_i = 12'h123;
        ex(P_IRQ, 1, "R9 pending");
        ex(P_MEMAD, 16'h0000, "R10 step0 address");
        ex(P_MEMWE, 0, "R10 step0 no write");
        tick(); idle(3'd1); pc_i = 12'h005;
        ex(P_MEMWE, 1, "R10 step1 write");
        ex(P_MEMAD, 16'h0000, "R10 step1 address");
        ex(P_MEMWD, 16'h0123, "R10 saved pc");
        ex(P_PCCLR, 1, "R10 pc clear");
        tick(); idle(3'd2); pc_i = 12'h000;
        ex(P_PCINC, 1, "R10 pc to one");
        ex(P_SEQCLR, 1, "R10 seq clear");
        ex(P_MEMWE, 0, "R10 step2 no write");
        tick(); idle(3'd4); pc_i = 12'h001;
        ex(P_IRQ, 0, "R10 pending cleared");
        ex(P_IEN, 0, "R10 enable cleared");
        tick();
        ex(P_IRQ, 0, "R9 stays idle when disabled");

        tick();
        tick();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule